// File: doc/BRIEF.md
# Bus Master Attribute Tagger with Register Access Filter

This block wraps a bus peripheral that has no notion of security on its own and gives it two small guards. On its outgoing master channel, a tagger stamps every request with a security bit, a privilege bit and a compartment identifier, all taken from programmed registers. The address and valid signals pass straight through. On its register port, a filter decides whether each incoming access may reach the peripheral. The decision depends on whether the access is secure and whether it is privileged. A refused read returns zero, and a refused write never reaches the peripheral.

Both halves come out of reset fully open. The two halves are also coupled: the tagger may only emit a secure request while the filter insists on secure access to the peripheral. Without that rule, non-secure software could reprogram a master that runs with secure rights. A single configuration write port programs both halves. That port accepts only writes that are both secure and privileged. Every refused access, on either port, raises a one-cycle illegal-access pulse on the cycle after it.

Top module: `bus_attr_gate`

## Requirements
- R1: After reset the master side emits requests as non-secure, unprivileged, with compartment identifier 0.
- R2: After reset every register access reaches the peripheral, whatever its security and privilege bits.
- R3: When the filter's secure-required bit (filter word bit 0) is set, an access with slvSec low is refused and one with slvSec high is admitted, subject to R4.
- R4: When the filter's privileged-required bit (filter word bit 1) is set, an access with slvPriv low is refused and one with slvPriv high is admitted, subject to R3.
- R5: A tag-word write (cfgSel=0) sets the compartment identifier from bits [3:0], the privilege attribute from bit 4 and the secure attribute from bit 5. These values apply to every outgoing master request from the next cycle on.
- R6: mstSecOut is high only when the programmed secure attribute and the filter's secure-required bit are both set. Otherwise the master emits non-secure.
- R7: A refused access drives perValid low and slvRdata to zero in the same cycle. illegalPulse is high for exactly the following cycle.
- R8: A configuration write with cfgSec or cfgPriv low changes neither the tag word nor the filter word (cfgSel=1). It raises illegalPulse on the following cycle.
- R9: The master address and valid signals and the applied attributes are combinational from their inputs and registers, so they add no cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWe | input | 1 | Configuration write strobe |
| cfgSel | input | 1 | 0 selects the tag word, 1 selects the filter word |
| cfgWdata | input | 8 | Configuration write data |
| cfgSec | input | 1 | Security bit of the configuration write |
| cfgPriv | input | 1 | Privilege bit of the configuration write |
| mstValidIn | input | 1 | Request valid from the wrapped master |
| mstAddrIn | input | 16 | Request address from the wrapped master |
| mstValidOut | output | 1 | Request valid to the bus |
| mstAddrOut | output | 16 | Request address to the bus |
| mstSecOut | output | 1 | Applied security attribute |
| mstPrivOut | output | 1 | Applied privilege attribute |
| mstCidOut | output | 4 | Applied compartment identifier |
| slvValid | input | 1 | Incoming register access valid |
| slvWrite | input | 1 | Incoming access is a write |
| slvAddr | input | 16 | Incoming access address |
| slvWdata | input | 32 | Incoming write data |
| slvSec | input | 1 | Incoming access is secure |
| slvPriv | input | 1 | Incoming access is privileged |
| slvRdata | output | 32 | Read data returned, zero when refused |
| perValid | output | 1 | Admitted access valid to the peripheral |
| perWrite | output | 1 | Admitted access is a write |
| perAddr | output | 16 | Address to the peripheral |
| perWdata | output | 32 | Write data to the peripheral |
| perRdata | input | 32 | Read data from the peripheral |
| illegalPulse | output | 1 | One-cycle flag for any refused access |

## Verification
The assertions watch on every cycle that a refused or unforwarded access returns zero data and that each refused slave or configuration access is followed by the illegal pulse. They also check that a dropped configuration write leaves both programmed words untouched and that reset clears both words. The coupling between the tagger's secure output and the filter setting can only be shown by the bench's scenarios. The same holds for the exact field positions of the configuration words and the pulse lasting a single cycle. In those scenarios the tag is programmed before and after the filter tightens, and the filter is walked through each of its four settings.

// File: rtl/bag_pkg.sv
package bag_pkg;
  parameter int unsigned BAG_CID_W = 4;

  typedef struct packed {
    logic                 tagSec;
    logic                 tagPriv;
    logic [BAG_CID_W-1:0] tagCid;
    logic                 slvGrant;
  } bag_strobe_t;
endpackage

// File: rtl/bag_ctrl.sv
module bag_ctrl
  import bag_pkg::*;
#(
  parameter int unsigned CFG_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWe,
  input  logic             cfgSel,
  input  logic [CFG_W-1:0] cfgWdata,
  input  logic             cfgSec,
  input  logic             cfgPriv,
  input  logic             slvValid,
  input  logic             slvSec,
  input  logic             slvPriv,
  output bag_strobe_t      strobes,
  output logic             illegalPulse
);
  localparam int unsigned CID_W    = BAG_CID_W;
  localparam int unsigned PRIV_BIT = CID_W;
  localparam int unsigned SEC_BIT  = CID_W + 1;
  localparam int unsigned FREQ_SEC  = 0;
  localparam int unsigned FREQ_PRIV = 1;

  logic             tagSecQ, tagPrivQ;
  logic [CID_W-1:0] tagCidQ;
  logic             reqSecQ, reqPrivQ;
  logic             illegalQ;

  logic cfgOk, cfgDrop, tagWr, filtWr, grant, slvDeny;

  always_comb begin
    cfgOk   = cfgSec & cfgPriv;
    cfgDrop = cfgWe & ~cfgOk;
    tagWr   = cfgWe & cfgOk & ~cfgSel;
    filtWr  = cfgWe & cfgOk & cfgSel;
    grant   = (~reqSecQ | slvSec) & (~reqPrivQ | slvPriv);
    slvDeny = slvValid & ~grant;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tagSecQ  <= 1'b0;
      tagPrivQ <= 1'b0;
      tagCidQ  <= '0;
    end else if (tagWr) begin
      tagSecQ  <= cfgWdata[SEC_BIT];
      tagPrivQ <= cfgWdata[PRIV_BIT];
      tagCidQ  <= cfgWdata[CID_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqSecQ  <= 1'b0;
      reqPrivQ <= 1'b0;
    end else if (filtWr) begin
      reqSecQ  <= cfgWdata[FREQ_SEC];
      reqPrivQ <= cfgWdata[FREQ_PRIV];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) illegalQ <= 1'b0;
    else       illegalQ <= slvDeny | cfgDrop;
  end

  always_comb begin
    strobes.tagSec   = tagSecQ & reqSecQ;
    strobes.tagPriv  = tagPrivQ;
    strobes.tagCid   = tagCidQ;
    strobes.slvGrant = grant;
  end

  assign illegalPulse = illegalQ;

  // R1, R2: reset clears the tag and filter words
  a_r1_reset_open: assert property (@(posedge clk)
    !rstN |=> (!tagSecQ && !tagPrivQ && tagCidQ == '0 && !reqSecQ && !reqPrivQ));

  // R8: a dropped configuration write leaves both words stable
  a_r8_cfg_guard: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWe && !(cfgSec && cfgPriv)) |=>
      $stable({tagSecQ, tagPrivQ, tagCidQ, reqSecQ, reqPrivQ}));

  // R8: a dropped configuration write is flagged
  a_r8_cfg_flag: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWe && !(cfgSec && cfgPriv)) |=> illegalPulse);

  // R7: a refused slave access is flagged next cycle
  a_r7_deny_flag: assert property (@(posedge clk) disable iff (!rstN)
    (slvValid && !strobes.slvGrant) |=> illegalPulse);

  // R7: no pulse without a refused access the cycle before
  a_r7_no_spurious: assert property (@(posedge clk) disable iff (!rstN)
    (!slvValid && !cfgWe) |=> !illegalPulse);
endmodule

// File: rtl/bag_data.sv
module bag_data
  import bag_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  bag_strobe_t          strobes,
  input  logic                 mstValidIn,
  input  logic [ADDR_W-1:0]    mstAddrIn,
  output logic                 mstValidOut,
  output logic [ADDR_W-1:0]    mstAddrOut,
  output logic                 mstSecOut,
  output logic                 mstPrivOut,
  output logic [BAG_CID_W-1:0] mstCidOut,
  input  logic                 slvValid,
  input  logic                 slvWrite,
  input  logic [ADDR_W-1:0]    slvAddr,
  input  logic [DATA_W-1:0]    slvWdata,
  output logic [DATA_W-1:0]    slvRdata,
  output logic                 perValid,
  output logic                 perWrite,
  output logic [ADDR_W-1:0]    perAddr,
  output logic [DATA_W-1:0]    perWdata,
  input  logic [DATA_W-1:0]    perRdata
);
  always_comb begin
    mstValidOut = mstValidIn;
    mstAddrOut  = mstAddrIn;
    mstSecOut   = strobes.tagSec;
    mstPrivOut  = strobes.tagPriv;
    mstCidOut   = strobes.tagCid;
  end

  always_comb begin
    perValid = slvValid & strobes.slvGrant;
    perWrite = slvWrite;
    perAddr  = slvAddr;
    perWdata = slvWdata;
    slvRdata = (perValid && !slvWrite) ? perRdata : '0;
  end

  // R7: no data leaks back unless the access was forwarded
  a_r7_zero_read: assert property (@(posedge clk) disable iff (!rstN)
    !perValid |-> slvRdata == '0);

  // R9: the master request passes through in the same cycle
  a_r9_same_cycle: assert property (@(posedge clk) disable iff (!rstN)
    mstValidOut == mstValidIn);
endmodule

// File: rtl/bus_attr_gate.sv
module bus_attr_gate
  import bag_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CFG_W  = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cfgWe,
  input  logic                 cfgSel,
  input  logic [CFG_W-1:0]     cfgWdata,
  input  logic                 cfgSec,
  input  logic                 cfgPriv,
  input  logic                 mstValidIn,
  input  logic [ADDR_W-1:0]    mstAddrIn,
  output logic                 mstValidOut,
  output logic [ADDR_W-1:0]    mstAddrOut,
  output logic                 mstSecOut,
  output logic                 mstPrivOut,
  output logic [BAG_CID_W-1:0] mstCidOut,
  input  logic                 slvValid,
  input  logic                 slvWrite,
  input  logic [ADDR_W-1:0]    slvAddr,
  input  logic [DATA_W-1:0]    slvWdata,
  input  logic                 slvSec,
  input  logic                 slvPriv,
  output logic [DATA_W-1:0]    slvRdata,
  output logic                 perValid,
  output logic                 perWrite,
  output logic [ADDR_W-1:0]    perAddr,
  output logic [DATA_W-1:0]    perWdata,
  input  logic [DATA_W-1:0]    perRdata,
  output logic                 illegalPulse
);
  bag_strobe_t strobes;

  bag_ctrl #(.CFG_W(CFG_W)) ctrl_i (
    .clk(clk), .rstN(rstN),
    .cfgWe(cfgWe), .cfgSel(cfgSel), .cfgWdata(cfgWdata),
    .cfgSec(cfgSec), .cfgPriv(cfgPriv),
    .slvValid(slvValid), .slvSec(slvSec), .slvPriv(slvPriv),
    .strobes(strobes), .illegalPulse(illegalPulse)
  );

  bag_data #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) data_i (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .mstValidIn(mstValidIn), .mstAddrIn(mstAddrIn),
    .mstValidOut(mstValidOut), .mstAddrOut(mstAddrOut),
    .mstSecOut(mstSecOut), .mstPrivOut(mstPrivOut), .mstCidOut(mstCidOut),
    .slvValid(slvValid), .slvWrite(slvWrite), .slvAddr(slvAddr),
    .slvWdata(slvWdata), .slvRdata(slvRdata),
    .perValid(perValid), .perWrite(perWrite), .perAddr(perAddr),
    .perWdata(perWdata), .perRdata(perRdata)
  );
endmodule

// File: tb/bus_attr_gate_tb_top.sv
`timescale 1ns/1ps
module bus_attr_gate_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWe = 0, cfgSel = 0, cfgSec = 0, cfgPriv = 0;
  logic [7:0] cfgWdata = '0;
  logic mstValidIn = 0;
  logic [15:0] mstAddrIn = '0;
  logic mstValidOut, mstSecOut, mstPrivOut;
  logic [15:0] mstAddrOut;
  logic [3:0] mstCidOut;
  logic slvValid = 0, slvWrite = 0, slvSec = 0, slvPriv = 0;
  logic [15:0] slvAddr = '0;
  logic [31:0] slvWdata = '0;
  logic [31:0] slvRdata, perWdata, perRdata;
  logic perValid, perWrite, illegalPulse;
  logic [15:0] perAddr;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  assign perRdata = {16'hC0DE, perAddr};

  bus_attr_gate dut_i (
    .clk(clk), .rstN(rstN),
    .cfgWe(cfgWe), .cfgSel(cfgSel), .cfgWdata(cfgWdata),
    .cfgSec(cfgSec), .cfgPriv(cfgPriv),
    .mstValidIn(mstValidIn), .mstAddrIn(mstAddrIn),
    .mstValidOut(mstValidOut), .mstAddrOut(mstAddrOut),
    .mstSecOut(mstSecOut), .mstPrivOut(mstPrivOut), .mstCidOut(mstCidOut),
    .slvValid(slvValid), .slvWrite(slvWrite), .slvAddr(slvAddr),
    .slvWdata(slvWdata), .slvSec(slvSec), .slvPriv(slvPriv),
    .slvRdata(slvRdata), .perValid(perValid), .perWrite(perWrite),
    .perAddr(perAddr), .perWdata(perWdata), .perRdata(perRdata),
    .illegalPulse(illegalPulse)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // configuration write; pulse checked on the cycle after
  task automatic cfg_write(input logic sel, input logic [7:0] data,
                           input logic sec, input logic priv, input string req);
    @(negedge clk);
    cfgWe = 1; cfgSel = sel; cfgWdata = data; cfgSec = sec; cfgPriv = priv;
    @(negedge clk);
    cfgWe = 0;
    chk(req, {31'd0, illegalPulse}, {31'd0, !(sec && priv)});
  endtask

  // one slave access; expect admitted or refused
  task automatic slv_access(input logic wr, input logic sec, input logic priv,
                            input logic [15:0] addr, input logic expOk, input string req);
    @(negedge clk);
    slvValid = 1; slvWrite = wr; slvSec = sec; slvPriv = priv;
    slvAddr = addr; slvWdata = 32'h1234_0000 | addr;
    #1;
    chk(req, {31'd0, perValid}, {31'd0, expOk});
    if (!wr) chk(req, slvRdata, expOk ? {16'hC0DE, addr} : 32'd0);
    else if (expOk) chk(req, perWdata, 32'h1234_0000 | addr);
    @(negedge clk);
    slvValid = 0;
    chk("R7", {31'd0, illegalPulse}, {31'd0, !expOk});
    @(negedge clk);
    chk("R7", {31'd0, illegalPulse}, 32'd0);
  endtask

  task automatic chk_tag(input logic sec, input logic priv, input logic [3:0] cid, input string req);
    @(negedge clk);
    mstValidIn = 1; mstAddrIn = 16'hBEEF;
    #1;
    chk(req, {31'd0, mstSecOut}, {31'd0, sec});
    chk(req, {31'd0, mstPrivOut}, {31'd0, priv});
    chk(req, {28'd0, mstCidOut}, {28'd0, cid});
    chk("R9", {15'd0, mstValidOut, mstAddrOut}, {15'd0, 1'b1, 16'hBEEF});
    mstValidIn = 0;
    #1;
    chk("R9", {31'd0, mstValidOut}, 32'd0);
  endtask

  task automatic t_reset_defaults();
    chk_tag(0, 0, 4'd0, "R1");
    slv_access(0, 0, 0, 16'h0040, 1, "R2");
    slv_access(1, 0, 0, 16'h0044, 1, "R2");
  endtask

  task automatic t_cfg_guard();
    cfg_write(0, 8'h3F, 0, 1, "R8");
    cfg_write(0, 8'h3F, 1, 0, "R8");
    cfg_write(1, 8'h03, 0, 0, "R8");
    chk_tag(0, 0, 4'd0, "R8");
    slv_access(0, 0, 0, 16'h0048, 1, "R8");
  endtask

  task automatic t_tag_program();
    cfg_write(0, 8'h35, 1, 1, "R5");  // sec=1 priv=1 cid=5
    chk_tag(0, 1, 4'd5, "R6");        // filter open -> non-secure
    cfg_write(0, 8'h0A, 1, 1, "R5");  // sec=0 priv=0 cid=A
    chk_tag(0, 0, 4'hA, "R5");
    cfg_write(0, 8'h2C, 1, 1, "R5");  // sec=1 priv=0 cid=C
  endtask

  task automatic t_filter_modes();
    cfg_write(1, 8'h01, 1, 1, "R3");  // require secure
    chk_tag(1, 0, 4'hC, "R6");
    slv_access(0, 0, 1, 16'h0050, 0, "R3");
    slv_access(1, 0, 1, 16'h0054, 0, "R3");
    slv_access(0, 1, 0, 16'h0058, 1, "R3");
    cfg_write(1, 8'h02, 1, 1, "R4");  // require privileged only
    chk_tag(0, 0, 4'hC, "R6");
    slv_access(1, 1, 0, 16'h0060, 0, "R4");
    slv_access(1, 0, 1, 16'h0064, 1, "R4");
    cfg_write(1, 8'h03, 1, 1, "R4");  // require both
    slv_access(0, 1, 0, 16'h0070, 0, "R4");
    slv_access(0, 0, 1, 16'h0074, 0, "R3");
    slv_access(0, 1, 1, 16'h0078, 1, "R3");
    chk_tag(1, 0, 4'hC, "R6");
  endtask

  task automatic t_reset_again();
    @(negedge clk);
    rstN = 0;
    @(negedge clk);
    rstN = 1;
    chk_tag(0, 0, 4'd0, "R1");
    slv_access(0, 0, 0, 16'h0080, 1, "R2");
  endtask

  initial begin
    #(4 * 100000);
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    t_reset_defaults();
    t_cfg_guard();
    t_tag_program();
    t_filter_modes();
    t_reset_again();
    repeat (2) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule